// File: doc/BRIEF.md
# Address-Generation Execute Unit

This block executes one register-indexed address-generation instruction against a private file of sixteen 32-bit general registers. A caller presents a 32-bit instruction word with a valid strobe and an addressing-mode select. The unit decodes the word and reads the two operand registers it names. It adds them to a 12-bit unsigned displacement, clears the high bits that the selected mode excludes, and writes the result into the named target register. Memory is never touched, and the unit never produces an exception, an overflow or a condition code.

The result is captured at the first rising edge after the valid cycle and reported with a one-cycle `done` pulse. It is committed to the register file at the following edge. Issue can run every cycle: an operand that names the register still waiting to commit is forwarded from the pending result. A preload port writes registers directly, and a combinational debug port reads them. The debug port also shows a pending result.

Top module: `addr_gen_unit`

## Requirements
- R1: Instruction fields are opcode `instr[31:24]`, target `instr[23:20]`, index `instr[19:16]`, base `instr[15:12]` and displacement `instr[11:0]`. A word with opcode 8'h41 and `in_valid` high produces `done` high for exactly the next cycle. `done` and `bad_op` stay low after a cycle with `in_valid` low.
- R2: The result is the zero-extended displacement plus the base operand plus the index operand, with the sum taken modulo 2^32 before masking.
- R3: A base field of 0 contributes zero, whatever register 0 holds.
- R4: An index field of 0 contributes zero, whatever register 0 holds.
- R5: With `wide_mode` = 1, bit 31 of the written value is 0.
- R6: With `wide_mode` = 0, bits 31:24 of the written value are 0.
- R7: Register 0 can be the target and is written like any other register.
- R8: An instruction whose displacement, base and index fields are all zero clears its target.
- R9: A valid word whose opcode is not 8'h41 raises `bad_op` for one cycle, keeps `done` low, and leaves every register unchanged.
- R10: An instruction issued in the cycle right after another uses the earlier result when its base or index field names the earlier target.
- R11: A low `rst_n` at a rising edge clears all sixteen registers, `done` and `bad_op`.
- R12: `pl_we` writes `pl_data` into register `pl_idx` at the rising edge. `dbg_data` shows register `dbg_idx` combinationally, or the pending result while `done` is high and `dbg_idx` equals its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| wide_mode | input | 1 | 1: 31-bit result, 0: 24-bit result |
| pl_we | input | 1 | Preload write enable |
| pl_idx | input | 4 | Preload register number |
| pl_data | input | 32 | Preload value |
| dbg_idx | input | 4 | Debug read register number |
| dbg_data | output | 32 | Debug read value |
| done | output | 1 | Result captured, commits at the next edge |
| bad_op | output | 1 | Previous valid word had an unsupported opcode |

## Verification
The bench loads register 0 with a nonzero pattern. A unit that read register 0 as a base or index operand would therefore give a visibly wrong sum. It chains instructions on consecutive cycles that increment the same register through the base slot and through the index slot. Without forwarding, every step after the first would repeat a stale value. Operands near 2^32 test two things: the truncation before masking, where a carry would otherwise survive, and the two masks, where a wrong mask would leak bit 31 or the high byte. An unsupported opcode is followed by a read of its target, which would show the value if the write had not been blocked.

// File: rtl/agu_pkg.sv
// Package agu_pkg: shared instruction layout and constants for the
// address-generation unit. Assumes the fixed 32-bit register-indexed format.
package agu_pkg;
    localparam int REG_NUM_W = 4;
    localparam int DISP_W    = 12;
    localparam int NUM_REGS  = 1 << REG_NUM_W;

    typedef struct packed {
        logic [7:0]           opc;
        logic [REG_NUM_W-1:0] tgt;
        logic [REG_NUM_W-1:0] idx;
        logic [REG_NUM_W-1:0] base;
        logic [DISP_W-1:0]    disp;
    } agu_instr_t;
endpackage

// File: rtl/agu_decode.sv
// Module agu_decode: splits the instruction word into fields and flags
// whether the opcode is the supported one. Purely combinational.
module agu_decode
    import agu_pkg::*;
#(
    parameter logic [7:0] OPCODE = 8'h41
) (
    input  logic [31:0]          instr,
    output logic [REG_NUM_W-1:0] tgt,
    output logic [REG_NUM_W-1:0] idx,
    output logic [REG_NUM_W-1:0] base,
    output logic [DISP_W-1:0]    disp,
    output logic                 legal
);
    agu_instr_t fields;

    // Reinterpret the word through the packed layout.
    always_comb begin
        fields = agu_instr_t'(instr);
        tgt    = fields.tgt;
        idx    = fields.idx;
        base   = fields.base;
        disp   = fields.disp;
        legal  = (fields.opc == OPCODE);
    end
endmodule

// File: rtl/agu_operand.sv
// Module agu_operand: produces one address operand. A field of zero yields a
// literal zero. A field matching the pending (uncommitted) target takes the
// pending value. Otherwise the register-file read is used.
module agu_operand #(
    parameter int XLEN = 32,
    parameter int RW   = 4
) (
    input  logic [RW-1:0]   sel,
    input  logic [XLEN-1:0] rf_val,
    input  logic            fwd_en,
    input  logic [RW-1:0]   fwd_tgt,
    input  logic [XLEN-1:0] fwd_val,
    output logic [XLEN-1:0] val
);
    // Zero slot first, then forwarding, then the stored value.
    always_comb begin
        if (sel == '0)
            val = '0;
        else if (fwd_en && (fwd_tgt == sel))
            val = fwd_val;
        else
            val = rf_val;
    end
endmodule

// File: rtl/agu_sum.sv
// Module agu_sum: three-term sum truncated to XLEN, then masked by mode.
// Assumes NARROW_W < XLEN. The wide mode clears only the top bit.
module agu_sum #(
    parameter int XLEN     = 32,
    parameter int DISP_W   = 12,
    parameter int NARROW_W = 24
) (
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   base_v,
    input  logic [XLEN-1:0]   idx_v,
    input  logic              wide_mode,
    output logic [XLEN-1:0]   result
);
    localparam logic [XLEN-1:0] WIDE_MASK   = {1'b0, {(XLEN-1){1'b1}}};
    localparam logic [XLEN-1:0] NARROW_MASK = {{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [XLEN:0]   full_sum;
    logic [XLEN-1:0] trunc_sum;

    // Add with carry-out, drop the carry, apply the mode mask.
    always_comb begin
        full_sum  = {1'b0, base_v} + {1'b0, idx_v} + (XLEN+1)'(disp);
        trunc_sum = full_sum[XLEN-1:0];
        result    = trunc_sum & (wide_mode ? WIDE_MASK : NARROW_MASK);
    end
endmodule

// File: rtl/agu_regfile.sv
// Module agu_regfile: NREGS x XLEN register file with a commit port and a
// preload port (preload wins on a same-register clash), two operand reads
// and one debug read, all combinational. Synchronous active-low clear.
module agu_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 16,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cm_we,
    input  logic [AW-1:0]   cm_addr,
    input  logic [XLEN-1:0] cm_data,
    input  logic            pl_we,
    input  logic [AW-1:0]   pl_addr,
    input  logic [XLEN-1:0] pl_data,
    input  logic [AW-1:0]   ra_addr,
    output logic [XLEN-1:0] ra_data,
    input  logic [AW-1:0]   rb_addr,
    output logic [XLEN-1:0] rb_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [XLEN-1:0] rd_data
);
    logic [XLEN-1:0] mem [NREGS];

    // Storage update: clear on reset, commit, then preload (last wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else begin
            if (cm_we) mem[cm_addr] <= cm_data;
            if (pl_we) mem[pl_addr] <= pl_data;
        end
    end

    // Asynchronous read ports.
    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
    assign rd_data = mem[rd_addr];

    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cm_we && !(pl_we && pl_addr == cm_addr)) |=> (mem[$past(cm_addr)] == $past(cm_data))); // R7
    AST_PRELOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pl_we) |=> (mem[$past(pl_addr)] == $past(pl_data))); // R12
endmodule

// File: rtl/addr_gen_unit.sv
// Module addr_gen_unit: executes the load-address style instruction.
// Cycle N: decode, read operands (with forwarding), compute.
// Edge N: capture result, done/bad_op. Edge N+1: commit into the file.
// Assumes in_valid is ignored while rst_n is low.
module addr_gen_unit
    import agu_pkg::*;
#(
    parameter int         XLEN     = 32,
    parameter int         NARROW_W = 24,
    parameter logic [7:0] OPCODE   = 8'h41
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [31:0]          instr,
    input  logic                 wide_mode,
    input  logic                 pl_we,
    input  logic [REG_NUM_W-1:0] pl_idx,
    input  logic [XLEN-1:0]      pl_data,
    input  logic [REG_NUM_W-1:0] dbg_idx,
    output logic [XLEN-1:0]      dbg_data,
    output logic                 done,
    output logic                 bad_op
);
    localparam int NSLOT = 2;

    logic [REG_NUM_W-1:0] d_tgt, d_idx, d_base;
    logic [DISP_W-1:0]    d_disp;
    logic                 d_legal;

    logic [REG_NUM_W-1:0] slot_sel [NSLOT];
    logic [XLEN-1:0]      slot_rf  [NSLOT];
    logic [XLEN-1:0]      slot_val [NSLOT];

    logic [XLEN-1:0]      sum_res;
    logic [XLEN-1:0]      rf_dbg;
    logic                 done_q, bad_q;
    logic [REG_NUM_W-1:0] wb_tgt;
    logic [XLEN-1:0]      wb_val;

    agu_decode #(.OPCODE(OPCODE)) u_dec (
        .instr(instr), .tgt(d_tgt), .idx(d_idx), .base(d_base),
        .disp(d_disp), .legal(d_legal)
    );

    // Slot 0 is the base operand, slot 1 the index operand.
    assign slot_sel[0] = d_base;
    assign slot_sel[1] = d_idx;

    agu_regfile #(.XLEN(XLEN), .NREGS(NUM_REGS)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .cm_we(done_q), .cm_addr(wb_tgt), .cm_data(wb_val),
        .pl_we(pl_we), .pl_addr(pl_idx), .pl_data(pl_data),
        .ra_addr(slot_sel[0]), .ra_data(slot_rf[0]),
        .rb_addr(slot_sel[1]), .rb_data(slot_rf[1]),
        .rd_addr(dbg_idx), .rd_data(rf_dbg)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_opnd
        agu_operand #(.XLEN(XLEN), .RW(REG_NUM_W)) u_opnd (
            .sel(slot_sel[s]), .rf_val(slot_rf[s]),
            .fwd_en(done_q), .fwd_tgt(wb_tgt), .fwd_val(wb_val),
            .val(slot_val[s])
        );
    end

    agu_sum #(.XLEN(XLEN), .DISP_W(DISP_W), .NARROW_W(NARROW_W)) u_sum (
        .disp(d_disp), .base_v(slot_val[0]), .idx_v(slot_val[1]),
        .wide_mode(wide_mode), .result(sum_res)
    );

    // Result stage: capture legal results, pulse done or bad_op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            bad_q  <= 1'b0;
            wb_tgt <= '0;
            wb_val <= '0;
        end else begin
            done_q <= in_valid && d_legal;
            bad_q  <= in_valid && !d_legal;
            if (in_valid && d_legal) begin
                wb_tgt <= d_tgt;
                wb_val <= sum_res;
            end
        end
    end

    // Debug read sees the pending result before it commits.
    assign dbg_data = (done_q && dbg_idx == wb_tgt) ? wb_val : rf_dbg;
    assign done     = done_q;
    assign bad_op   = bad_q;

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && d_legal) |=> (done && !bad_op)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!done && !bad_op)); // R1
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !d_legal) |=> (bad_op && !done)); // R9
    AST_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && d_legal && wide_mode) |=> (wb_val[XLEN-1] == 1'b0)); // R5
    AST_HIGH_BYTE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && d_legal && !wide_mode) |=> (wb_val[XLEN-1:NARROW_W] == '0)); // R6
endmodule

// File: tb/addr_gen_unit_tb.sv
// Bench addr_gen_unit_tb: directed corner cases plus seeded random stream,
// compared against a bench-side register model.
module addr_gen_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr;
    logic        wide_mode;
    logic        pl_we;
    logic [3:0]  pl_idx;
    logic [31:0] pl_data;
    logic [3:0]  dbg_idx;
    logic [31:0] dbg_data;
    logic        done;
    logic        bad_op;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] model [16];
    bit          p_v;
    bit          p_legal;
    logic [3:0]  p_tgt;
    logic [31:0] p_val;
    string       p_req;

    always #10 clk = ~clk;

    addr_gen_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .wide_mode(wide_mode), .pl_we(pl_we), .pl_idx(pl_idx), .pl_data(pl_data),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data), .done(done), .bad_op(bad_op)
    );

    function automatic logic [31:0] mk(input logic [7:0] opc, input logic [3:0] t,
                                       input logic [3:0] x, input logic [3:0] b,
                                       input logic [11:0] d);
        return {opc, t, x, b, d};
    endfunction

    function automatic logic [31:0] expect_val(input logic [31:0] ins, input bit wide);
        logic [32:0] s;
        logic [31:0] bv, xv, t;
        bv = (ins[15:12] == 4'd0) ? 32'd0 : model[ins[15:12]];
        xv = (ins[19:16] == 4'd0) ? 32'd0 : model[ins[19:16]];
        s  = {21'd0, ins[11:0]} + {1'b0, bv} + {1'b0, xv};
        t  = s[31:0];
        return wide ? {1'b0, t[30:0]} : {8'd0, t[23:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check the previous issue, then drive the next one.
    task automatic step(input bit v, input logic [31:0] ins, input bit wide,
                        input string req);
        @(negedge clk);
        if (p_v) begin
            dbg_idx = p_tgt;
            #1;
            if (p_legal) begin
                chk(done === 1'b1, {p_req, " done"}, {31'd0, done}, 32'd1);
                chk(bad_op === 1'b0, {p_req, " bad_op"}, {31'd0, bad_op}, 32'd0);
                chk(dbg_data === p_val, {p_req, " value"}, dbg_data, p_val);
            end else begin
                chk(bad_op === 1'b1, "R9 bad_op", {31'd0, bad_op}, 32'd1);
                chk(done === 1'b0, "R9 done", {31'd0, done}, 32'd0);
                chk(dbg_data === model[p_tgt], "R9 target kept", dbg_data, model[p_tgt]);
            end
        end else begin
            #1;
            chk(done === 1'b0 && bad_op === 1'b0, "R1 idle quiet", {30'd0, done, bad_op}, 32'd0);
        end
        in_valid  = v;
        instr     = ins;
        wide_mode = wide;
        p_v       = v;
        if (v) begin
            p_tgt   = ins[23:20];
            p_legal = (ins[31:24] == 8'h41);
            p_req   = req;
            if (p_legal) begin
                p_val        = expect_val(ins, wide);
                model[p_tgt] = p_val;
            end
        end
    endtask

    task automatic preload(input logic [3:0] r, input logic [31:0] val);
        step(1'b0, 32'd0, 1'b1, "");
        @(negedge clk);
        pl_we = 1'b1; pl_idx = r; pl_data = val;
        @(negedge clk);
        pl_we    = 1'b0;
        model[r] = val;
        dbg_idx  = r;
        #1;
        chk(dbg_data === val, "R12 preload readback", dbg_data, val);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; instr = '0; wide_mode = 1'b1;
        pl_we = 1'b0; pl_idx = '0; pl_data = '0; dbg_idx = '0;
        p_v = 1'b0; p_legal = 1'b0; p_tgt = '0; p_val = '0; p_req = "";
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(done === 1'b0 && bad_op === 1'b0, "R11 flags after reset", {30'd0, done, bad_op}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            dbg_idx = 4'(i);
            #1;
            chk(dbg_data === 32'd0, "R11 register cleared", dbg_data, 32'd0);
        end

        preload(4'd0, 32'hDEAD_BEEF);
        preload(4'd1, 32'h0000_0010);
        preload(4'd2, 32'h0000_0020);
        preload(4'd3, 32'hFFFF_FFFF);
        preload(4'd4, 32'h1234_5678);
        preload(4'd12, 32'hCAFE_F00D);

        step(1'b1, mk(8'h41, 4'd5, 4'd0, 4'd0, 12'h123), 1'b1, "R3 R4 immediate");
        step(1'b1, mk(8'h41, 4'd6, 4'd0, 4'd2, 12'd5), 1'b1, "R4 index zero");
        step(1'b1, mk(8'h41, 4'd7, 4'd2, 4'd0, 12'd5), 1'b1, "R3 base zero");
        step(1'b1, mk(8'h41, 4'd8, 4'd1, 4'd2, 12'hFFF), 1'b1, "R2 three terms");
        step(1'b1, mk(8'h41, 4'd9, 4'd3, 4'd3, 12'd3), 1'b1, "R2 wrap");
        step(1'b1, mk(8'h41, 4'd10, 4'd3, 4'd0, 12'd0), 1'b1, "R5 top bit");
        step(1'b1, mk(8'h41, 4'd11, 4'd3, 4'd0, 12'd0), 1'b0, "R6 high byte");
        step(1'b1, mk(8'h41, 4'd0, 4'd1, 4'd0, 12'd4), 1'b1, "R7 target zero");
        step(1'b1, mk(8'h41, 4'd12, 4'd0, 4'd0, 12'd0), 1'b1, "R8 clear");
        for (int k = 0; k < 4; k++)
            step(1'b1, mk(8'h41, 4'd1, 4'd0, 4'd1, 12'd1), 1'b1, "R10 base chain");
        for (int k = 0; k < 4; k++)
            step(1'b1, mk(8'h41, 4'd2, 4'd2, 4'd0, 12'd7), 1'b1, "R10 index chain");
        step(1'b1, mk(8'h5A, 4'd4, 4'd0, 4'd0, 12'd7), 1'b1, "R9 illegal");
        step(1'b1, mk(8'h41, 4'd13, 4'd0, 4'd4, 12'd0), 1'b1, "R9 target intact");
        step(1'b0, 32'd0, 1'b1, "");

        for (int n = 0; n < 500; n++) begin
            logic [3:0]  t, x, b;
            logic [11:0] d;
            logic [7:0]  opc;
            bit          v, w;
            v   = ($urandom % 5) != 0;
            w   = $urandom % 2;
            t   = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 4);
            x   = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 4);
            b   = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 4);
            case ($urandom % 4)
                0: d = 12'd0;
                1: d = 12'hFFF;
                default: d = 12'($urandom);
            endcase
            opc = ($urandom % 10 == 0) ? 8'($urandom | 1) ^ 8'h40 : 8'h41;
            if (n % 50 == 0) begin
                preload(4'($urandom), $urandom);
            end
            step(v, mk(opc, t, x, b, d), w, "R2 random");
        end
        step(1'b0, 32'd0, 1'b1, "");
        step(1'b0, 32'd0, 1'b1, "");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule